// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Busy Arbitration

This block is a synchronous model of a true dual-port static RAM. A left and a right port each carry a chip enable, a write select, an output enable, two byte-lane selects, an address and separate write and read data buses. Both ports may read or write any word in the same clock cycle, and all state changes happen on the rising clock edge.

When both ports are enabled on the same address in the same cycle, the block detects the collision. In master mode it grants the left port, raises a busy flag toward the right port and drops the right port's write. In slave mode the block stops judging collisions on its own. Each port instead obeys a busy input from an external master, so that several of these blocks can sit side by side to build a wider word with one arbiter for all of them.

A write to one port is seen on the other port one cycle later. A read on the same cycle as an opposite-port write to the same word returns the old content, which models the port-to-port flow-through delay.

Top module: `dpram_arb`

## Requirements
- R1: After synchronous reset, both read data outputs are zero while chip enable and output enable are high, until a read is performed.
- R2: A read happens at a rising edge where chip enable is 1 and write select is 0. The addressed word appears on that port's read data from that edge on and is held until the port's next read.
- R3: A port's read data is all zeros whenever its chip enable or its output enable is 0.
- R4: A write happens only at an edge where chip enable and write select are both 1. With write select 1 and chip enable 0 the memory is unchanged.
- R5: Lane select bits: the lower select covers data bits [H-1:0] and the upper select covers bits [WIDTH-1:H], where H = WIDTH/2. A write changes only the selected lanes. A read returns zeros in the lanes that were not selected.
- R6: In master mode (mode input 1), the right busy output is 1 in exactly the cycles where both chip enables are 1 and the addresses are equal. The left busy output is always 0.
- R7: In master mode, during a same-address collision the right port's write is suppressed and the left port's write takes effect.
- R8: In slave mode (mode input 0), both busy outputs are 0. A busy input of 1 blocks that port's write, and that port's reads are unaffected.
- R9: In master mode the busy inputs are ignored.
- R10: When one port writes a word and the other port reads the same word in the same cycle, the reader gets the previous content. A read one cycle later returns the new content.
- R11: Writes by both ports to different addresses in the same cycle both take effect and raise no busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = block arbitrates and drives busy, 0 = busy taken from inputs |
| l_ce | input | 1 | Left chip enable |
| l_we | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper lane select |
| l_lb | input | 1 | Left lower lane select |
| l_addr | input | AW | Left word address |
| l_wdata | input | WIDTH | Left write data |
| l_rdata | output | WIDTH | Left read data |
| l_busy_in | input | 1 | Left busy from external master (slave mode) |
| l_busy_out | output | 1 | Left busy flag (master mode) |
| r_ce | input | 1 | Right chip enable |
| r_we | input | 1 | Right write select (1 write, 0 read) |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper lane select |
| r_lb | input | 1 | Right lower lane select |
| r_addr | input | AW | Right word address |
| r_wdata | input | WIDTH | Right write data |
| r_rdata | output | WIDTH | Right read data |
| r_busy_in | input | 1 | Right busy from external master (slave mode) |
| r_busy_out | output | 1 | Right busy flag (master mode) |

## Verification
Two activities can fall on the same edge: a write through one port, and a read or a write through the other port to the same word. The bench provokes this by driving both ports onto one address in one cycle, with write against read and with write against write. It checks the busy flag in that same cycle. It then judges the result on the next cycles: the reader's data must be the old word, a follow-up read must return the new word, and on a write-write collision only the left value may remain. The same collisions are repeated in slave mode, where only the external busy inputs decide which write is blocked.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int DEF_DEPTH = 4096;
    localparam int DEF_WIDTH = 18;
    localparam int NUM_LANES = 2;
    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

    typedef enum logic { MODE_SLAVE = 1'b0, MODE_MASTER = 1'b1 } mode_e;

    typedef struct packed {
        logic                 rd;
        logic                 wr;
        logic [NUM_LANES-1:0] lanes;
    } port_op_t;

    function automatic logic [NUM_LANES-1:0] lane_sel(input logic upper, input logic lower);
        return {upper, lower};
    endfunction

    function automatic mode_e to_mode(input logic m);
        return m ? MODE_MASTER : MODE_SLAVE;
    endfunction

endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec
    import dpram_pkg::*;
(
    input  logic     ce,
    input  logic     we,
    input  logic     ub,
    input  logic     lb,
    input  logic     block,
    output port_op_t op
);
    logic [NUM_LANES-1:0] lanes;

    always_comb begin
        lanes    = lane_sel(ub, lb);
        op.lanes = lanes;
        op.rd    = ce & ~we;
        op.wr    = ce & we & (|lanes) & ~block;
    end
endmodule

// File: rtl/dpram_contend.sv
module dpram_contend
    import dpram_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          master_mode,
    input  logic          l_ce,
    input  logic          r_ce,
    input  logic [AW-1:0] l_addr,
    input  logic [AW-1:0] r_addr,
    input  logic          l_busy_in,
    input  logic          r_busy_in,
    output logic          l_block,
    output logic          r_block,
    output logic          l_busy_out,
    output logic          r_busy_out
);
    mode_e mode;
    logic  same_word;

    always_comb begin
        mode      = to_mode(master_mode);
        same_word = l_ce & r_ce & (l_addr == r_addr);
        unique case (mode)
            MODE_MASTER: begin
                l_busy_out = 1'b0;
                r_busy_out = same_word;
                l_block    = 1'b0;
                r_block    = same_word;
            end
            default: begin
                l_busy_out = 1'b0;
                r_busy_out = 1'b0;
                l_block    = l_busy_in;
                r_block    = r_busy_in;
            end
        endcase
    end
endmodule

// File: rtl/dpram_array.sv
module dpram_array
    import dpram_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int HW   = WIDTH / NUM_LANES
) (
    input  logic                clk,
    input  logic                rst,
    input  port_op_t            op    [NUM_PORTS],
    input  logic [AW-1:0]       addr  [NUM_PORTS],
    input  logic [WIDTH-1:0]    wdata [NUM_PORTS],
    output logic [WIDTH-1:0]    rword [NUM_PORTS]
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rmask [NUM_PORTS];

    // Right port first so that the left port wins an unblocked double write.
    always_ff @(posedge clk) begin
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (op[p].wr) begin
                for (int g = 0; g < NUM_LANES; g++) begin
                    if (op[p].lanes[g])
                        mem[addr[p]][g*HW +: HW] <= wdata[p][g*HW +: HW];
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            assign rmask[p][g*HW +: HW] = {HW{op[p].lanes[g]}};
        end

        always_ff @(posedge clk) begin
            if (rst)
                rword[p] <= '0;
            else if (op[p].rd)
                rword[p] <= mem[addr[p]] & rmask[p];
        end
    end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
    import dpram_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_mode,
    input  logic             l_ce,
    input  logic             l_we,
    input  logic             l_oe,
    input  logic             l_ub,
    input  logic             l_lb,
    input  logic [AW-1:0]    l_addr,
    input  logic [WIDTH-1:0] l_wdata,
    output logic [WIDTH-1:0] l_rdata,
    input  logic             l_busy_in,
    output logic             l_busy_out,
    input  logic             r_ce,
    input  logic             r_we,
    input  logic             r_oe,
    input  logic             r_ub,
    input  logic             r_lb,
    input  logic [AW-1:0]    r_addr,
    input  logic [WIDTH-1:0] r_wdata,
    output logic [WIDTH-1:0] r_rdata,
    input  logic             r_busy_in,
    output logic             r_busy_out
);
    logic             ce_v  [NUM_PORTS];
    logic             we_v  [NUM_PORTS];
    logic             oe_v  [NUM_PORTS];
    logic             ub_v  [NUM_PORTS];
    logic             lb_v  [NUM_PORTS];
    logic             blk_v [NUM_PORTS];
    logic [AW-1:0]    addr_v[NUM_PORTS];
    logic [WIDTH-1:0] wd_v  [NUM_PORTS];
    logic [WIDTH-1:0] rw_v  [NUM_PORTS];
    logic [WIDTH-1:0] rd_v  [NUM_PORTS];
    port_op_t         op_v  [NUM_PORTS];
    logic             l_block, r_block;

    always_comb begin
        ce_v[PORT_L] = l_ce;     ce_v[PORT_R] = r_ce;
        we_v[PORT_L] = l_we;     we_v[PORT_R] = r_we;
        oe_v[PORT_L] = l_oe;     oe_v[PORT_R] = r_oe;
        ub_v[PORT_L] = l_ub;     ub_v[PORT_R] = r_ub;
        lb_v[PORT_L] = l_lb;     lb_v[PORT_R] = r_lb;
        addr_v[PORT_L] = l_addr; addr_v[PORT_R] = r_addr;
        wd_v[PORT_L] = l_wdata;  wd_v[PORT_R] = r_wdata;
        blk_v[PORT_L] = l_block; blk_v[PORT_R] = r_block;
    end

    dpram_contend #(.AW(AW)) i_contend (
        .master_mode (master_mode),
        .l_ce        (l_ce),
        .r_ce        (r_ce),
        .l_addr      (l_addr),
        .r_addr      (r_addr),
        .l_busy_in   (l_busy_in),
        .r_busy_in   (r_busy_in),
        .l_block     (l_block),
        .r_block     (r_block),
        .l_busy_out  (l_busy_out),
        .r_busy_out  (r_busy_out)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpram_port_dec i_dec (
            .ce    (ce_v[p]),
            .we    (we_v[p]),
            .ub    (ub_v[p]),
            .lb    (lb_v[p]),
            .block (blk_v[p]),
            .op    (op_v[p])
        );
        assign rd_v[p] = (ce_v[p] & oe_v[p]) ? rw_v[p] : '0;
    end

    dpram_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_array (
        .clk   (clk),
        .rst   (rst),
        .op    (op_v),
        .addr  (addr_v),
        .wdata (wd_v),
        .rword (rw_v)
    );

    assign l_rdata = rd_v[PORT_L];
    assign r_rdata = rd_v[PORT_R];
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
    parameter int AW    = 12,
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             master_mode,
    input logic             l_ce,
    input logic             l_we,
    input logic             l_oe,
    input logic             r_ce,
    input logic             r_we,
    input logic             r_oe,
    input logic [AW-1:0]    l_addr,
    input logic [AW-1:0]    r_addr,
    input logic [WIDTH-1:0] l_rdata,
    input logic [WIDTH-1:0] r_rdata,
    input logic             l_busy_out,
    input logic             r_busy_out
);
    AST_LEFT_NEVER_BUSY: assert property (@(posedge clk) disable iff (rst)
        !l_busy_out); // R6
    AST_RBUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        r_busy_out |-> (master_mode && l_ce && r_ce && l_addr == r_addr)); // R6
    AST_SLAVE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> (!l_busy_out && !r_busy_out)); // R8
    AST_L_RDATA_GATED: assert property (@(posedge clk) disable iff (rst)
        !(l_ce && l_oe) |-> (l_rdata == '0)); // R3
    AST_R_RDATA_GATED: assert property (@(posedge clk) disable iff (rst)
        !(r_ce && r_oe) |-> (r_rdata == '0)); // R3
    AST_L_HOLD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (l_ce && l_we && l_oe) |=> ((l_ce && l_oe) |-> (l_rdata == $past(l_rdata)))); // R2
    AST_R_HOLD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (r_ce && r_we && r_oe) |=> ((r_ce && r_oe) |-> (r_rdata == $past(r_rdata)))); // R2
endmodule

bind dpram_arb dpram_arb_chk #(.AW(AW), .WIDTH(WIDTH)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .master_mode (master_mode),
    .l_ce        (l_ce),
    .l_we        (l_we),
    .l_oe        (l_oe),
    .r_ce        (r_ce),
    .r_we        (r_we),
    .r_oe        (r_oe),
    .l_addr      (l_addr),
    .r_addr      (r_addr),
    .l_rdata     (l_rdata),
    .r_rdata     (r_rdata),
    .l_busy_out  (l_busy_out),
    .r_busy_out  (r_busy_out)
);

// File: tb/test_dpram_arb.sv
module test_dpram_arb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4096;
    localparam int WIDTH = 18;
    localparam int AW    = $clog2(DEPTH);
    localparam int HW    = WIDTH / 2;
    localparam logic [WIDTH-1:0] LMASK = {{(WIDTH-HW){1'b0}}, {HW{1'b1}}};
    localparam logic [WIDTH-1:0] UMASK = ~LMASK;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_mode = 1'b1;
    logic l_ce = 0, l_we = 0, l_oe = 0, l_ub = 0, l_lb = 0, l_busy_in = 0;
    logic r_ce = 0, r_we = 0, r_oe = 0, r_ub = 0, r_lb = 0, r_busy_in = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [WIDTH-1:0] l_wdata = '0, r_wdata = '0;
    logic [WIDTH-1:0] l_rdata, r_rdata;
    logic l_busy_out, r_busy_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_arb #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_dpram_arb (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        l_ce = 0; l_we = 0; l_oe = 0; l_ub = 0; l_lb = 0;
        r_ce = 0; r_we = 0; r_oe = 0; r_ub = 0; r_lb = 0;
    endtask

    task automatic set_l(input logic ce, we, oe, ub, lb, input int a, input logic [WIDTH-1:0] d);
        l_ce = ce; l_we = we; l_oe = oe; l_ub = ub; l_lb = lb; l_addr = AW'(a); l_wdata = d;
    endtask

    task automatic set_r(input logic ce, we, oe, ub, lb, input int a, input logic [WIDTH-1:0] d);
        r_ce = ce; r_we = we; r_oe = oe; r_ub = ub; r_lb = lb; r_addr = AW'(a); r_wdata = d;
    endtask

    task automatic wr(input int side, input int a, input logic [WIDTH-1:0] d);
        if (side == 0) set_l(1, 1, 0, 1, 1, a, d); else set_r(1, 1, 0, 1, 1, a, d);
        step(); idle();
    endtask

    task automatic rd(input int side, input int a, output logic [WIDTH-1:0] q);
        if (side == 0) set_l(1, 0, 1, 1, 1, a, '0); else set_r(1, 0, 1, 1, 1, a, '0);
        step();
        q = (side == 0) ? l_rdata : r_rdata;
        idle();
    endtask

    task automatic t_reset();
        logic [WIDTH-1:0] q;
        set_l(1, 1, 1, 1, 1, 0, '0); l_we = 0;
        set_r(1, 0, 1, 1, 1, 1, '0);
        #1;
        check("R1 left rdata after reset", l_rdata, '0);
        check("R1 right rdata after reset", r_rdata, '0);
        check("R6 no busy after reset", {16'b0, l_busy_out, r_busy_out}, '0);
        idle(); step();
        wr(0, 2, 18'h1_2345);
        rd(1, 2, q);
        check("R2 right reads left write", q, 18'h1_2345);
    endtask

    task automatic t_read_gate();
        logic [WIDTH-1:0] q;
        wr(1, 7, 18'h2_BEEF);
        rd(0, 7, q);
        check("R2 left reads word", q, 18'h2_BEEF);
        l_ce = 1; l_oe = 0; l_we = 1; l_ub = 0; l_lb = 0; #1;
        check("R3 oe low gives zero", l_rdata, '0);
        l_oe = 1; l_ce = 0; #1;
        check("R3 ce low gives zero", l_rdata, '0);
        l_ce = 1; l_we = 1; #1;
        check("R2 held word visible again", l_rdata, 18'h2_BEEF);
        step(); idle();
    endtask

    task automatic t_write_qual();
        logic [WIDTH-1:0] q;
        wr(0, 9, 18'h0_0AAA);
        set_l(0, 1, 0, 1, 1, 9, 18'h3_FFFF); step(); idle();
        rd(0, 9, q);
        check("R4 we without ce ignored", q, 18'h0_0AAA);
        set_r(1, 1, 0, 0, 0, 9, 18'h3_FFFF); step(); idle();
        rd(1, 9, q);
        check("R5 no lanes selected no change", q, 18'h0_0AAA);
    endtask

    task automatic t_lanes();
        logic [WIDTH-1:0] q;
        logic [WIDTH-1:0] old_w = 18'h2_A5A5;
        logic [WIDTH-1:0] nw    = 18'h1_FF00;
        wr(0, 5, old_w);
        set_l(1, 1, 0, 1, 0, 5, nw); step(); idle();
        rd(1, 5, q);
        check("R5 upper lane write", q, (nw & UMASK) | (old_w & LMASK));
        set_r(1, 1, 0, 0, 1, 5, 18'h0_0033); step(); idle();
        rd(0, 5, q);
        check("R5 lower lane write", q, (nw & UMASK) | 18'h0_0033);
        set_l(1, 0, 1, 0, 1, 5, '0); step();
        check("R5 lower lane read masks upper", l_rdata, 18'h0_0033);
        idle();
        set_r(1, 0, 1, 1, 0, 5, '0); step();
        check("R5 upper lane read masks lower", r_rdata, nw & UMASK);
        idle();
    endtask

    task automatic t_wr_rd_collide();
        logic [WIDTH-1:0] q;
        master_mode = 1;
        wr(1, 20, 18'h0_1111);
        set_l(1, 1, 0, 1, 1, 20, 18'h0_2222);
        set_r(1, 0, 1, 1, 1, 20, '0);
        #1;
        check("R6 right busy on match", {17'b0, r_busy_out}, 18'h1);
        check("R6 left never busy", {17'b0, l_busy_out}, 18'h0);
        step();
        check("R10 reader sees old word", r_rdata, 18'h0_1111);
        set_l(0, 0, 0, 0, 0, 20, '0);
        #1;
        check("R6 busy clears without match", {17'b0, r_busy_out}, 18'h0);
        step();
        check("R10 next read sees new word", r_rdata, 18'h0_2222);
        idle();
        // left reads while blocked right writes the same word
        set_l(1, 0, 1, 1, 1, 21, '0);
        wr(0, 21, 18'h0_0777);
        set_l(1, 0, 1, 1, 1, 21, '0);
        set_r(1, 1, 0, 1, 1, 21, 18'h3_0000);
        step(); idle();
        rd(0, 21, q);
        check("R7 blocked right write leaves word", q, 18'h0_0777);
    endtask

    task automatic t_wr_wr();
        logic [WIDTH-1:0] q;
        master_mode = 1;
        set_l(1, 1, 0, 1, 1, 30, 18'h0_AAAA);
        set_r(1, 1, 0, 1, 1, 30, 18'h1_5555);
        step(); idle();
        rd(1, 30, q);
        check("R7 left wins double write", q, 18'h0_AAAA);
        set_l(1, 1, 0, 1, 1, 40, 18'h0_4040);
        set_r(1, 1, 0, 1, 1, 41, 18'h0_4141);
        #1;
        check("R11 no busy on distinct words", {16'b0, l_busy_out, r_busy_out}, '0);
        step(); idle();
        rd(0, 41, q);
        check("R11 right distinct write", q, 18'h0_4141);
        rd(1, 40, q);
        check("R11 left distinct write", q, 18'h0_4040);
    endtask

    task automatic t_master_ignores_in();
        logic [WIDTH-1:0] q;
        master_mode = 1; l_busy_in = 1; r_busy_in = 1;
        wr(1, 50, 18'h0_5050);
        wr(0, 51, 18'h0_5151);
        #1;
        check("R9 busy out unaffected", {16'b0, l_busy_out, r_busy_out}, '0);
        l_busy_in = 0; r_busy_in = 0;
        rd(0, 50, q);
        check("R9 right write despite busy in", q, 18'h0_5050);
        rd(1, 51, q);
        check("R9 left write despite busy in", q, 18'h0_5151);
    endtask

    task automatic t_slave();
        logic [WIDTH-1:0] q;
        master_mode = 0;
        wr(0, 60, 18'h0_0060);
        r_busy_in = 1;
        set_l(1, 0, 1, 1, 1, 60, '0);
        set_r(1, 1, 0, 1, 1, 60, 18'h3_3333);
        #1;
        check("R8 slave no busy out on match", {16'b0, l_busy_out, r_busy_out}, '0);
        step(); idle();
        rd(1, 60, q);
        check("R8 right read while busy in", q, 18'h0_0060);
        r_busy_in = 0; l_busy_in = 1;
        set_l(1, 1, 0, 1, 1, 61, 18'h1_1111);
        set_r(1, 1, 0, 1, 1, 61, 18'h2_2222);
        step(); idle();
        l_busy_in = 0;
        rd(0, 61, q);
        check("R8 left blocked right written", q, 18'h2_2222);
        master_mode = 1;
    endtask

    initial begin
        repeat (3) step();
        rst = 0;
        t_reset();
        t_read_gate();
        t_write_qual();
        t_lanes();
        t_wr_rd_collide();
        t_wr_wr();
        t_master_ignores_in();
        t_slave();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule